// File: doc/BRIEF.md
# Multiplex-by-four LCD segment driver

This block drives a segment LCD wired for 1/4 multiplexing: four backplane outputs and a parameterised number of frontplane outputs (32 by default, so 128 segments). Each segment is owned by exactly one bit of display memory. The bits are used as they are, with no character or segment decoding. Software loads a full frame serially into a staging register, one bit per shift-enable cycle. A single load strobe then copies the whole staging register into the display latch, so the visible image never shows a half-written frame.

A timing generator runs from a one-cycle oscillator enable. It steps the active backplane through phases 0..3 and inverts the drive polarity after every full pass, so each segment has zero net DC across it. Every output is a 2-bit level code: 0 means ground, 1 means one third, 2 means two thirds and 3 means full scale. An analog stage outside this block turns the codes into voltages. Each backplane step opens a high-drive window of a fixed number of oscillator periods, during which the pads may use their strong drivers. A frame-sync pulse marks the entry into phase 0.

Top module: `lcd_mux4_driver`

## Requirements
- R1: After reset the display latch is all zeros, the phase is 0, polarity is positive, `hi_drive` is 0 and `frame_sync` is 0. Backplane 0 shows code 3, the other backplanes code 1, and every frontplane code 2.
- R2: Each cycle with `ser_en` high shifts `ser_bit` into the staging register at index 0, and the older bits move one place up. After 128 shifts, the first bit sent sits at index 127. A `latch_load` cycle copies the staging content from before that edge into the latch. Latch bit `4*j + p` controls frontplane j during phase p.
- R3: Shifting without `latch_load` leaves every frontplane code unchanged.
- R4: The phase advances by one, wrapping 3 to 0, on every `TICKS_PER_PHASE`-th `osc_tick`, and at no other time.
- R5: Polarity inverts on the edge where the phase wraps from 3 to 0, and only then.
- R6: With positive polarity the active backplane shows code 3 and the others code 1. With negative polarity these become 0 and 2.
- R7: An "on" frontplane shows code 0 (positive polarity) or 3 (negative polarity). An "off" frontplane shows code 2 (positive) or 1 (negative).
- R8: `hi_drive` rises on the edge that changes the phase. It falls after exactly `BOOST_TICKS` further `osc_tick` pulses.
- R9: `frame_sync` is high for exactly one clock cycle, the one that starts right after the phase becomes 0 through a wrap.
- R10: Over any eight consecutive phases, the sum of backplane code minus frontplane code is zero for every backplane/frontplane pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator period enable |
| ser_en | input | 1 | Shift one bit into the staging register |
| ser_bit | input | 1 | Serial segment data |
| latch_load | input | 1 | Copy staging register into display latch |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per backplane |
| fp_lvl | output | 64 | Frontplane level codes, 2 bits per frontplane |
| hi_drive | output | 1 | High-current drive window active |
| frame_sync | output | 1 | One-cycle pulse on entry into phase 0 |

## Verification
The assertions assume that every input is a defined 0 or 1 once reset is released. They also assume that `osc_tick` may arrive in any pattern, including back-to-back cycles, and that shift and load may fall in the same cycle. The high-drive checks further take `BOOST_TICKS` to be below `TICKS_PER_PHASE`, which elaboration enforces. The bench changes inputs only on falling edges, with bits drawn from a fixed-seed generator. It mixes dense and sparse oscillator ticks, shifts and occasional loads, including loads that land in mid-phase and in the same cycle as a shift.

// File: rtl/lcd_mux4_pkg.sv
`timescale 1ns/1ps
package lcd_mux4_pkg;

   localparam int NUM_BP  = 4;
   localparam int PHASE_W = 2;

   typedef enum logic [1:0] {
      LVL_ZERO      = 2'd0,
      LVL_THIRD     = 2'd1,
      LVL_TWO_THIRD = 2'd2,
      LVL_FULL      = 2'd3
   } drive_lvl_e;

   // mirror a level about mid-scale, used for the negative polarity half
   function automatic drive_lvl_e flip_lvl(drive_lvl_e l);
      return drive_lvl_e'(2'd3 - l);
   endfunction

endpackage

// File: rtl/lcd_seg_loader.sv
`timescale 1ns/1ps
module lcd_seg_loader #(
   parameter int SEG_N    = 128,
   parameter bit SHIFT_UP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             shift_bit,
   input  logic             xfer,
   output logic [SEG_N-1:0] seg_latch
);

   logic [SEG_N-1:0] stage;

   generate
      if (SEG_N < 2) begin : g_bad_n
         $error("lcd_seg_loader: SEG_N must be at least 2");
      end
      if (SHIFT_UP) begin : g_up
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stage <= '0;
            else if (shift_en) stage <= {stage[SEG_N-2:0], shift_bit};
         end
      end else begin : g_down
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stage <= '0;
            else if (shift_en) stage <= {shift_bit, stage[SEG_N-1:1]};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seg_latch <= '0;
      else if (xfer) seg_latch <= stage;
   end

   // R3: the image only changes on a transfer
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(seg_latch));

   // R2: transfer takes the staging content from before the edge
   p_latch_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> seg_latch == $past(stage));

endmodule

// File: rtl/lcd_phase_timer.sv
`timescale 1ns/1ps
module lcd_phase_timer
   import lcd_mux4_pkg::*;
#(
   parameter int TICKS_PER_PHASE = 8,
   parameter int BOOST_TICKS     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               osc_tick,
   output logic [PHASE_W-1:0] phase,
   output logic               neg_pol,
   output logic               hi_drive,
   output logic               frame_sync
);

   localparam int CNT_W = $clog2(TICKS_PER_PHASE);
   localparam int BST_W = $clog2(BOOST_TICKS + 1);
   localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_BP - 1);

   generate
      if (TICKS_PER_PHASE < 2) begin : g_bad_tpp
         $error("lcd_phase_timer: TICKS_PER_PHASE must be at least 2");
      end
      if (BOOST_TICKS < 1 || BOOST_TICKS >= TICKS_PER_PHASE) begin : g_bad_bst
         $error("lcd_phase_timer: BOOST_TICKS must lie in 1..TICKS_PER_PHASE-1");
      end
   endgenerate

   logic [CNT_W-1:0] tick_cnt;
   logic [BST_W-1:0] boost_cnt;
   logic             phase_end;

   assign phase_end = osc_tick && (tick_cnt == CNT_W'(TICKS_PER_PHASE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt   <= '0;
         phase      <= '0;
         neg_pol    <= 1'b0;
         boost_cnt  <= '0;
         frame_sync <= 1'b0;
      end else begin
         frame_sync <= phase_end && (phase == LAST_PHASE);
         if (osc_tick) tick_cnt <= phase_end ? '0 : tick_cnt + 1'b1;
         if (phase_end) begin
            phase     <= phase + 1'b1;
            boost_cnt <= BST_W'(BOOST_TICKS);
            if (phase == LAST_PHASE) neg_pol <= ~neg_pol;
         end else if (osc_tick && boost_cnt != '0) begin
            boost_cnt <= boost_cnt - 1'b1;
         end
      end
   end

   assign hi_drive = (boost_cnt != '0);

   // R4: phase only ever steps by one
   p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> (phase == PHASE_W'($past(phase) + 1'b1)));

   // R4: no oscillator tick, no phase change
   p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(phase));

   // R5: polarity flips only on the wrap into phase 0
   p_pol_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (neg_pol != $past(neg_pol)) |-> (phase == '0 && $past(phase) == LAST_PHASE));

   // R8: a backplane level change always opens the boost window
   p_boost_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> hi_drive);

   // R9: sync is a single-cycle pulse inside phase 0
   p_sync_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> !frame_sync);
   p_sync_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |-> (phase == '0));

endmodule

// File: rtl/lcd_level_mux.sv
`timescale 1ns/1ps
module lcd_level_mux
   import lcd_mux4_pkg::*;
#(
   parameter int NUM_FP      = 32,
   parameter bit PHASE_MAJOR = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_FP*NUM_BP-1:0]   seg_latch,
   input  logic [PHASE_W-1:0]         phase,
   input  logic                       neg_pol,
   output logic [NUM_BP*2-1:0]        bp_lvl,
   output logic [NUM_FP*2-1:0]        fp_lvl
);

   localparam int SEG_N = NUM_FP * NUM_BP;
   localparam int IDX_W = $clog2(SEG_N);

   logic [NUM_BP-1:0] bp_extreme;

   generate
      for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
         drive_lvl_e base, lvl;
         always_comb begin
            base = (phase == PHASE_W'(i)) ? LVL_FULL : LVL_THIRD;
            lvl  = neg_pol ? flip_lvl(base) : base;
         end
         assign bp_lvl[i*2 +: 2] = lvl;
         assign bp_extreme[i]    = (bp_lvl[i*2 +: 2] == 2'd0) || (bp_lvl[i*2 +: 2] == 2'd3);
      end

      for (genvar j = 0; j < NUM_FP; j++) begin : g_fp
         logic [IDX_W-1:0] sel;
         if (PHASE_MAJOR) begin : g_pm
            assign sel = IDX_W'(phase) * IDX_W'(NUM_FP) + IDX_W'(j);
         end else begin : g_fm
            assign sel = IDX_W'(j * NUM_BP) + IDX_W'(phase);
         end
         drive_lvl_e base, lvl;
         always_comb begin
            base = seg_latch[sel] ? LVL_ZERO : LVL_TWO_THIRD;
            lvl  = neg_pol ? flip_lvl(base) : base;
         end
         assign fp_lvl[j*2 +: 2] = lvl;
      end
   endgenerate

   // R6: exactly one backplane sits at a rail at any time
   p_one_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bp_extreme) == 1);

   // R7: a frontplane never reaches the rail the active backplane occupies
   p_fp_not_bp_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fp_lvl[1:0] != (neg_pol ? 2'd0 : 2'd3));

endmodule

// File: rtl/lcd_mux4_driver.sv
`timescale 1ns/1ps
module lcd_mux4_driver
   import lcd_mux4_pkg::*;
#(
   parameter int NUM_FP          = 32,
   parameter int TICKS_PER_PHASE = 8,
   parameter int BOOST_TICKS     = 4,
   parameter bit SHIFT_UP        = 1'b1,
   parameter bit PHASE_MAJOR     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                osc_tick,
   input  logic                ser_en,
   input  logic                ser_bit,
   input  logic                latch_load,
   output logic [NUM_BP*2-1:0] bp_lvl,
   output logic [NUM_FP*2-1:0] fp_lvl,
   output logic                hi_drive,
   output logic                frame_sync
);

   localparam int SEG_N = NUM_FP * NUM_BP;

   generate
      if (NUM_FP < 1) begin : g_bad_fp
         $error("lcd_mux4_driver: NUM_FP must be at least 1");
      end
   endgenerate

   logic [SEG_N-1:0]   seg_latch;
   logic [PHASE_W-1:0] phase;
   logic               neg_pol;

   lcd_seg_loader #(
      .SEG_N    (SEG_N),
      .SHIFT_UP (SHIFT_UP)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (ser_en),
      .shift_bit (ser_bit),
      .xfer      (latch_load),
      .seg_latch (seg_latch)
   );

   lcd_phase_timer #(
      .TICKS_PER_PHASE (TICKS_PER_PHASE),
      .BOOST_TICKS     (BOOST_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (osc_tick),
      .phase      (phase),
      .neg_pol    (neg_pol),
      .hi_drive   (hi_drive),
      .frame_sync (frame_sync)
   );

   lcd_level_mux #(
      .NUM_FP      (NUM_FP),
      .PHASE_MAJOR (PHASE_MAJOR)
   ) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .seg_latch (seg_latch),
      .phase     (phase),
      .neg_pol   (neg_pol),
      .bp_lvl    (bp_lvl),
      .fp_lvl    (fp_lvl)
   );

   // R1: the first cycles after reset show an all-off image
   p_reset_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!hi_drive && !frame_sync));

endmodule

// File: tb/tb_lcd_mux4_driver.sv
`timescale 1ns/1ps
module tb_lcd_mux4_driver;

   localparam int NFP  = 32;
   localparam int NSEG = NFP * 4;
   localparam int TPP  = 8;
   localparam int BT   = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic osc_tick = 1'b0, ser_en = 1'b0, ser_bit = 1'b0, latch_load = 1'b0;
   logic [7:0]       bp_lvl;
   logic [NFP*2-1:0] fp_lvl;
   logic             hi_drive, frame_sync;

   always #10 clk = ~clk;

   lcd_mux4_driver #(.NUM_FP(NFP), .TICKS_PER_PHASE(TPP), .BOOST_TICKS(BT)) dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ser_en(ser_en), .ser_bit(ser_bit),
      .latch_load(latch_load), .bp_lvl(bp_lvl), .fp_lvl(fp_lvl),
      .hi_drive(hi_drive), .frame_sync(frame_sync));

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   logic [NSEG-1:0] m_stage = '0, m_latch = '0;
   int m_phase = 0, m_cnt = 0, m_boost = 0;
   bit m_pol = 0, m_sync = 0;

   function automatic logic [1:0] exp_bp(int i);
      if (i == m_phase) return m_pol ? 2'd0 : 2'd3;
      return m_pol ? 2'd2 : 2'd1;
   endfunction

   function automatic logic [1:0] exp_fp(int j);
      bit on = m_latch[j*4 + m_phase];
      if (m_pol) return on ? 2'd3 : 2'd1;
      return on ? 2'd0 : 2'd2;
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [7:0]       eb;
      logic [NFP*2-1:0] ef;
      for (int i = 0; i < 4; i++)   eb[i*2 +: 2] = exp_bp(i);
      for (int j = 0; j < NFP; j++) ef[j*2 +: 2] = exp_fp(j);
      chk("R6", "bp_lvl", 64'(bp_lvl), 64'(eb));
      chk("R7", "fp_lvl", 64'(fp_lvl), 64'(ef));
      chk("R8", "hi_drive", 64'(hi_drive), 64'(m_boost != 0));
      chk("R9", "frame_sync", 64'(frame_sync), 64'(m_sync));
   endtask

   // drive after a falling edge, update the model at the rising edge,
   // compare at the next falling edge
   task automatic step(bit tk, bit se, bit sb, bit ld);
      bit adv;
      osc_tick = tk; ser_en = se; ser_bit = sb; latch_load = ld;
      @(posedge clk);
      if (ld) m_latch = m_stage;
      if (se) m_stage = {m_stage[NSEG-2:0], sb};
      adv    = tk && (m_cnt == TPP - 1);
      m_sync = adv && (m_phase == 3);
      if (tk) m_cnt = adv ? 0 : m_cnt + 1;
      if (adv) begin
         m_phase = (m_phase + 1) % 4;
         if (m_phase == 0) m_pol = !m_pol;
         m_boost = BT;
      end else if (tk && m_boost != 0) begin
         m_boost--;
      end
      @(negedge clk);
      osc_tick = 0; ser_en = 0; ser_bit = 0; latch_load = 0;
      compare_all();
   endtask

   task automatic shift_frame(logic [NSEG-1:0] v);
      for (int k = NSEG - 1; k >= 0; k--) step(1'b0, 1'b1, v[k], 1'b0);
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NSEG-1:0] pat;
      logic [NFP*2-1:0] saved;
      int dc [4][NFP];
      int bad;
      void'($urandom(32'h1CD4));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset image
      chk("R1", "bp_lvl", 64'(bp_lvl), 64'h57);
      chk("R1", "fp_lvl", 64'(fp_lvl), {32{2'b10}});
      chk("R1", "hi_drive", 64'(hi_drive), 64'd0);
      chk("R1", "frame_sync", 64'(frame_sync), 64'd0);

      // R4 and R8: first phase step and boost window
      ticks(TPP - 1);
      chk("R4", "bp before step", 64'(bp_lvl), 64'h57);
      ticks(1);
      chk("R4", "bp after step", 64'(bp_lvl), 64'h5D);
      chk("R8", "boost open", 64'(hi_drive), 64'd1);
      ticks(BT - 1);
      chk("R8", "boost still open", 64'(hi_drive), 64'd1);
      ticks(1);
      chk("R8", "boost closed", 64'(hi_drive), 64'd0);

      // R2: single marker bit lands at index 127 -> fp31 during phase 3
      shift_frame({1'b1, {(NSEG-1){1'b0}}});
      step(1'b0, 1'b0, 1'b0, 1'b1);
      while (m_phase != 3) step(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R2", "fp31 on in phase 3", 64'(fp_lvl[63:62]), 64'(m_pol ? 2'd3 : 2'd0));
      chk("R2", "fp0 off in phase 3", 64'(fp_lvl[1:0]), 64'(m_pol ? 2'd1 : 2'd2));

      // R2: full pattern load
      pat = {4{32'hA5C3_0F96}};
      shift_frame(pat);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R2", "latched pattern", 64'(m_latch == pat), 64'd1);

      // R3: shifting without load leaves frontplanes untouched
      saved = fp_lvl;
      for (int k = 0; k < 40; k++) step(1'b0, 1'b1, 1'($urandom), 1'b0);
      chk("R3", "fp after shifts", 64'(fp_lvl), 64'(saved));

      // R5 and R9: run to the wrap
      while (!(m_phase == 3 && m_cnt == TPP - 1)) step(1'b1, 1'b0, 1'b0, 1'b0);
      begin
         bit pol_before = m_pol;
         step(1'b1, 1'b0, 1'b0, 1'b0);
         chk("R5", "bp0 rail after wrap", 64'(bp_lvl[1:0]), 64'(pol_before ? 2'd3 : 2'd0));
         chk("R9", "sync after wrap", 64'(frame_sync), 64'd1);
         step(1'b0, 1'b0, 1'b0, 1'b0);
         chk("R9", "sync one cycle", 64'(frame_sync), 64'd0);
      end

      // R10: zero net DC over eight phases
      for (int k = 0; k < 4; k++) for (int j = 0; j < NFP; j++) dc[k][j] = 0;
      for (int p = 0; p < 8; p++) begin
         ticks(TPP);
         for (int k = 0; k < 4; k++)
            for (int j = 0; j < NFP; j++)
               dc[k][j] += int'(bp_lvl[k*2 +: 2]) - int'(fp_lvl[j*2 +: 2]);
      end
      bad = 0;
      for (int k = 0; k < 4; k++) for (int j = 0; j < NFP; j++) if (dc[k][j] != 0) bad++;
      chk("R10", "pairs with DC offset", 64'(bad), 64'd0);

      // random mix: sparse and dense ticks, shifts, occasional loads
      for (int n = 0; n < 6000; n++) begin
         bit tk = (n < 3000) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
         step(tk, 1'($urandom), 1'($urandom), ($urandom % 48) == 0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule